// File: doc/BRIEF.md
# Serial EEPROM-Style Memory Slave

This block is a two-wire serial bus slave in front of a 256-byte array that behaves like non-volatile storage. It sees the bus clock and data lines after filtering, drives the data line only by pulling it low, and answers to one 7-bit address: the fixed type nibble `1010` followed by three strap inputs. A write carries a word address byte and then any number of data bytes. The data bytes are staged in a four-byte page buffer and written to the array only when the master issues a stop. After that, a timed internal write cycle keeps the block busy.

Reads come from an internal address counter. A read with no word address returns the byte at the counter. A random read is a short write that carries only the word address, followed by a repeated start with the read bit set. A sequential read keeps going for as long as the master acknowledges, and the counter rolls over from 255 to 0. The block is meant for board-level bookkeeping data such as fault codes and manufacturing records.

The controller is one state machine with these states: `ST_IDLE`, `ST_DEVADDR`, `ST_DEVACK`, `ST_WADDR`, `ST_WAACK`, `ST_WDATA`, `ST_WDACK`, `ST_RDATA` and `ST_RACK`.

Transitions:
- A start condition in any state goes to `ST_DEVADDR`.
- A stop condition in any state goes to `ST_IDLE`.
- After the eighth bit of a byte:
  - `ST_DEVADDR` goes to `ST_DEVACK`.
  - `ST_WADDR` goes to `ST_WAACK`.
  - `ST_WDATA` goes to `ST_WDACK`.
  - `ST_RDATA` goes to `ST_RACK`.
- At the falling clock edge that ends an acknowledge slot:
  - `ST_DEVACK` goes to `ST_RDATA` if the address matched and the read bit is set, to `ST_WADDR` if it matched and the bit is clear, and otherwise to `ST_IDLE`.
  - `ST_WAACK` goes to `ST_WDATA`.
  - `ST_WDACK` goes to `ST_WDATA` if the byte was acknowledged, and otherwise to `ST_IDLE`.
  - `ST_RACK` goes to `ST_RDATA` if the master acknowledged, and otherwise to `ST_IDLE`.

Top module: `i2c_mem_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal `1010` followed by `strap_i[2:0]` (MSB first). Any other address is left unacknowledged: the data line is not pulled low in the ninth clock.
- R2: In a write transfer, the block acknowledges the word address byte, which is the first byte after the address byte, and each data byte that follows it.
- R3: Each data byte of a write goes to the page slot selected by the two low counter bits, and only those two bits increment. A fifth or later byte therefore wraps to the first location written and overwrites the byte held there.
- R4: At the stop, only page locations that received a byte in this transfer are written. The other bytes of the page and of the array are unchanged.
- R5: A stop that follows at least one accepted data byte raises `busy_o` for exactly `WCYC` clock cycles.
- R6: While `busy_o` is high, the block acknowledges no address byte.
- R7: A stop after only a word address starts no write cycle, and it leaves the counter loaded with that address.
- R8: The address counter holds n+1, kept within the page for writes, after location n is read or written. A read that has no word address returns the byte at the counter.
- R9: A write carrying only the word address, followed by a repeated start with the read bit set, returns data from that word address.
- R10: In a read, each master acknowledge moves the counter to the next location and sends that byte, rolling from 255 to 0. A master non-acknowledge ends the read.
- R11: With `wr_lock_i` high, data bytes are not acknowledged, no write cycle starts and the array keeps its contents. The word address is still acknowledged.
- R12: After reset, `busy_o` and `sda_oe_o` are low, every array byte reads 0xFF and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Filtered bus clock level |
| sda_i | input | 1 | Filtered bus data level |
| sda_oe_o | output | 1 | High pulls the data line low (open drain) |
| strap_i | input | 3 | Address strap bits, lowest three bits of the slave address |
| wr_lock_i | input | 1 | Write-control: high blocks data bytes |
| busy_o | output | 1 | High during the internal write cycle |

## Verification
Directed transfers probe the edges of the address comparison: a wrong strap value, another device's type nibble, and an address sent while a write cycle is running. Page writes of one, two and six bytes tell the LSB-only wrap apart from a full-address increment. They also tell masked commits apart from whole-page commits. A sequential read started at 0xFD crosses the top of the array, and the reads after a word-address-only stop separate counter loading from write-cycle start. Seeded random page writes of one to six bytes at random addresses are each read back as a whole page and compared with a bench model of the array and counter.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    // Transfer phase of the memory slave
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_DEVACK,
        ST_WADDR,
        ST_WAACK,
        ST_WDATA,
        ST_WDACK,
        ST_RDATA,
        ST_RACK
    } mst_e;

endpackage

// File: rtl/i2c_bus_cond.sv
// Synchronises the bus lines and flags clock edges and start/stop conditions.
module i2c_bus_cond #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_lvl,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC-1:0] scl_s, sda_s;
    logic            scl_p, sda_p, scl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_s <= '1;
            sda_s <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_s <= {scl_s[SYNC-2:0], scl_i};
            sda_s <= {sda_s[SYNC-2:0], sda_i};
            scl_p <= scl_s[SYNC-1];
            sda_p <= sda_s[SYNC-1];
        end
    end

    assign scl_q     = scl_s[SYNC-1];
    assign sda_lvl   = sda_s[SYNC-1];
    assign scl_rise  = scl_q & ~scl_p;
    assign scl_fall  = ~scl_q & scl_p;
    assign start_det = scl_q & scl_p & sda_p & ~sda_lvl;
    assign stop_det  = scl_q & scl_p & ~sda_p & sda_lvl;
endmodule

// File: rtl/i2c_page_buf.sv
// Staging buffer for one page, with a received-byte mask.
module i2c_page_buf #(
    parameter int PAGE = 4,
    localparam int PW  = $clog2(PAGE)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  we,
    input  logic [PW-1:0]         idx,
    input  logic [7:0]            wdata,
    output logic [PAGE-1:0][7:0]  data_o,
    output logic [PAGE-1:0]       valid_o
);
    for (genvar s = 0; s < PAGE; s++) begin : g_slot
        logic [7:0] d_q;
        logic       v_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                d_q <= '0;
                v_q <= 1'b0;
            end else if (clr) begin
                v_q <= 1'b0;
            end else if (we && idx == PW'(s)) begin
                d_q <= wdata;
                v_q <= 1'b1;
            end
        end
        assign data_o[s]  = d_q;
        assign valid_o[s] = v_q;
    end
endmodule

// File: rtl/i2c_mem_array.sv
// Register array standing in for the non-volatile cells; commits masked pages.
module i2c_mem_array #(
    parameter int WORDS = 256,
    parameter int PAGE  = 4,
    localparam int AW   = $clog2(WORDS),
    localparam int PW   = $clog2(PAGE),
    localparam int HW   = AW - PW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 commit,
    input  logic [HW-1:0]        page_sel,
    input  logic [PAGE-1:0][7:0] pdata,
    input  logic [PAGE-1:0]      pvalid,
    input  logic [AW-1:0]        rd_addr,
    output logic [7:0]           rd_data
);
    logic [7:0] mem [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= 8'hFF;
        end else if (commit) begin
            for (int s = 0; s < PAGE; s++)
                if (pvalid[s]) mem[{page_sel, PW'(s)}] <= pdata[s];
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
    import i2c_mem_pkg::*;
#(
    parameter int         WORDS   = 256,
    parameter int         PAGE    = 4,
    parameter int         WCYC    = 500000,
    parameter int         SYNC    = 2,
    parameter logic [3:0] DEV_TYPE = 4'b1010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [2:0] strap_i,
    input  logic       wr_lock_i,
    output logic       busy_o
);
    localparam int AW = $clog2(WORDS);
    localparam int PW = $clog2(PAGE);
    localparam int HW = AW - PW;
    localparam int CW = $clog2(WCYC) + 1;

    logic scl_rise, scl_fall, sda_q, start_det, stop_det;
    mst_e st, st_nx;
    logic [3:0]    bitcnt;
    logic [7:0]    shreg;
    logic          ack_q, ack_now, m_ack, sda_oe_q, busy_q;
    logic [AW-1:0] addr_cnt;
    logic [CW-1:0] wcnt;
    logic          byte_end, pb_we, pb_clr, commit;
    logic [PAGE-1:0][7:0] pb_data;
    logic [PAGE-1:0]      pb_valid;
    logic [7:0]           rd_data;

    i2c_bus_cond #(.SYNC(SYNC)) u_cond (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_q),
        .start_det(start_det), .stop_det(stop_det)
    );

    assign byte_end = scl_fall && bitcnt == 4'd8;
    assign pb_we    = st == ST_WDATA && byte_end && !wr_lock_i && !start_det && !stop_det;
    assign pb_clr   = start_det | stop_det;
    assign commit   = stop_det && |pb_valid;

    i2c_page_buf #(.PAGE(PAGE)) u_page (
        .clk(clk), .rst_n(rst_n), .clr(pb_clr), .we(pb_we),
        .idx(addr_cnt[PW-1:0]), .wdata(shreg),
        .data_o(pb_data), .valid_o(pb_valid)
    );

    i2c_mem_array #(.WORDS(WORDS), .PAGE(PAGE)) u_array (
        .clk(clk), .rst_n(rst_n), .commit(commit),
        .page_sel(addr_cnt[AW-1:PW]), .pdata(pb_data), .pvalid(pb_valid),
        .rd_addr(addr_cnt), .rd_data(rd_data)
    );

    // Acknowledge decision for the byte that is just complete
    always_comb begin
        unique case (st)
            ST_DEVADDR: ack_now = shreg[7:1] == {DEV_TYPE, strap_i} && !busy_q;
            ST_WADDR:   ack_now = 1'b1;
            ST_WDATA:   ack_now = !wr_lock_i;
            default:    ack_now = 1'b0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Next state
    always_comb begin
        st_nx = st;
        if (start_det)     st_nx = ST_DEVADDR;
        else if (stop_det) st_nx = ST_IDLE;
        else begin
            unique case (st)
                ST_IDLE:    st_nx = ST_IDLE;
                ST_DEVADDR: if (byte_end) st_nx = ST_DEVACK;
                ST_WADDR:   if (byte_end) st_nx = ST_WAACK;
                ST_WDATA:   if (byte_end) st_nx = ST_WDACK;
                ST_DEVACK:  if (scl_fall) st_nx = !ack_q ? ST_IDLE : (shreg[0] ? ST_RDATA : ST_WADDR);
                ST_WAACK:   if (scl_fall) st_nx = ST_WDATA;
                ST_WDACK:   if (scl_fall) st_nx = ack_q ? ST_WDATA : ST_IDLE;
                ST_RDATA:   if (byte_end) st_nx = ST_RACK;
                ST_RACK:    if (scl_fall) st_nx = m_ack ? ST_RDATA : ST_IDLE;
                default:    st_nx = ST_IDLE;
            endcase
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt   <= '0;
            shreg    <= '0;
            ack_q    <= 1'b0;
            m_ack    <= 1'b0;
            sda_oe_q <= 1'b0;
            busy_q   <= 1'b0;
            wcnt     <= '0;
            addr_cnt <= '0;
        end else begin
            if (commit) begin
                busy_q <= 1'b1;
                wcnt   <= '0;
            end else if (busy_q) begin
                if (wcnt == CW'(WCYC - 1)) busy_q <= 1'b0;
                else                       wcnt   <= wcnt + CW'(1);
            end

            if (start_det || stop_det) begin
                bitcnt   <= '0;
                sda_oe_q <= 1'b0;
            end else begin
                unique case (st)
                    ST_DEVADDR, ST_WADDR, ST_WDATA: begin
                        if (scl_rise && bitcnt < 4'd8) begin
                            shreg  <= {shreg[6:0], sda_q};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (byte_end) begin
                            bitcnt   <= '0;
                            sda_oe_q <= ack_now;
                            ack_q    <= ack_now;
                            if (st == ST_WADDR) addr_cnt <= shreg[AW-1:0];
                            if (pb_we) addr_cnt[PW-1:0] <= addr_cnt[PW-1:0] + PW'(1);
                        end
                    end
                    ST_DEVACK: begin
                        if (scl_fall) begin
                            if (ack_q && shreg[0]) begin
                                shreg    <= rd_data;
                                sda_oe_q <= ~rd_data[7];
                                addr_cnt <= addr_cnt + AW'(1);
                            end else begin
                                sda_oe_q <= 1'b0;
                            end
                        end
                    end
                    ST_WAACK, ST_WDACK: begin
                        if (scl_fall) sda_oe_q <= 1'b0;
                    end
                    ST_RDATA: begin
                        if (scl_rise && bitcnt < 4'd8) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                bitcnt   <= '0;
                                sda_oe_q <= 1'b0;
                            end else begin
                                shreg    <= {shreg[6:0], 1'b0};
                                sda_oe_q <= ~shreg[6];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            m_ack <= ~sda_q;
                        end else if (scl_fall && m_ack) begin
                            shreg    <= rd_data;
                            sda_oe_q <= ~rd_data[7];
                            addr_cnt <= addr_cnt + AW'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe_o = sda_oe_q;
    assign busy_o   = busy_q;
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk
    import i2c_mem_pkg::*;
#(
    parameter int AW   = 8,
    parameter int PW   = 2,
    parameter int WCYC = 500000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy_o,
    input logic          sda_oe_o,
    input logic          stop_det,
    input mst_e          st,
    input logic [AW-1:0] cnt
);
    localparam int BW = $clog2(WCYC + 1) + 1;
    logic [BW-1:0] busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      busy_len <= '0;
        else if (busy_o) busy_len <= busy_len + BW'(1);
        else             busy_len <= '0;
    end

    // R5: a write cycle starts only out of a stop condition
    a_r5_busy_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_det));

    // R5: the write cycle lasts exactly WCYC clocks
    a_r5_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> busy_len == BW'(WCYC));

    // R6: no acknowledge of the address byte while busy
    a_r6_busy_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DEVACK && busy_o) |-> !sda_oe_o);

    // R2: the line is pulled low only in acknowledge slots or read data
    a_r2_drive_phase: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe_o |-> (st == ST_DEVACK || st == ST_WAACK || st == ST_WDACK || st == ST_RDATA));

    // R3: the page bits of the counter hold still during data bytes
    a_r3_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_WDATA || st == ST_WDACK) && ($past(st) == ST_WDATA || $past(st) == ST_WDACK))
        |-> $stable(cnt[AW-1:PW]));
endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(.AW(AW), .PW(PW), .WCYC(WCYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .sda_oe_o(sda_oe_o),
    .stop_det(stop_det), .st(st), .cnt(addr_cnt)
);

// File: tb/i2c_mem_slave_tb.sv
module i2c_mem_slave_tb;
    localparam int         WCYC  = 300;
    localparam int         Q     = 6;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, lock = 1'b0;
    logic sda_oe, busy;
    wire  sda_line;

    always #5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    i2c_mem_slave #(.WCYC(WCYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .strap_i(STRAP), .wr_lock_i(lock), .busy_o(busy)
    );

    int n_chk = 0, n_err = 0;
    int busy_run = 0, busy_last = 0;
    logic [7:0] mem_m [256];
    logic [7:0] cnt_m;
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];

    always @(negedge clk) begin
        if (busy) busy_run++;
        else begin
            if (busy_run != 0) busy_last = busy_run;
            busy_run = 0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] page_step(input logic [7:0] base, input int k);
        return {base[7:2], 2'(int'(base[1:0]) + k)};
    endfunction

    function automatic logic [7:0] dev(input logic [2:0] s, input bit rd);
        return {4'b1010, s, rd};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        ack = ~sda_line; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
            d[i] = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
        end
        sda_m = ~give_ack; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic wait_idle();
        while (busy) tick(1);
        tick(2);
    endtask

    // write transfer; model updated from the requirements
    task automatic mem_write(input logic [7:0] wa, input int len, input string tag);
        bit a;
        i2c_start();
        send_byte(dev(STRAP, 1'b0), a); chk({tag, " R1 dev ack"}, a, 1);
        send_byte(wa, a);               chk({tag, " R2 waddr ack"}, a, 1);
        cnt_m = wa;
        for (int k = 0; k < len; k++) begin
            send_byte(wbuf[k], a);
            chk({tag, " R2/R11 data ack"}, a, lock ? 0 : 1);
            if (!lock) begin
                mem_m[page_step(wa, k)] = wbuf[k];
                cnt_m = page_step(wa, k + 1);
            end
            if (lock) break;
        end
        i2c_stop();
    endtask

    task automatic read_tail(input int n);
        for (int k = 0; k < n; k++) recv_byte(k != n - 1, rbuf[k]);
        i2c_stop();
    endtask

    task automatic rand_read(input logic [7:0] wa, input int n, input string tag);
        bit a;
        i2c_start();
        send_byte(dev(STRAP, 1'b0), a); chk({tag, " R9 dev ack"}, a, 1);
        send_byte(wa, a);               chk({tag, " R9 waddr ack"}, a, 1);
        i2c_start();
        send_byte(dev(STRAP, 1'b1), a); chk({tag, " R9 read ack"}, a, 1);
        read_tail(n);
        cnt_m = wa;
        for (int k = 0; k < n; k++) begin
            chk({tag, " read data"}, rbuf[k], mem_m[cnt_m]);
            cnt_m = cnt_m + 8'd1;
        end
    endtask

    task automatic cur_read(input int n, input string tag);
        bit a;
        i2c_start();
        send_byte(dev(STRAP, 1'b1), a); chk({tag, " R8 dev ack"}, a, 1);
        read_tail(n);
        for (int k = 0; k < n; k++) begin
            chk({tag, " current read"}, rbuf[k], mem_m[cnt_m]);
            cnt_m = cnt_m + 8'd1;
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        bit a;
        void'($urandom(32'd4711));
        for (int i = 0; i < 256; i++) mem_m[i] = 8'hFF;
        cnt_m = 8'd0;
        tick(5); rst_n = 1'b1; tick(5);

        chk("R12 busy after reset", busy, 0);
        chk("R12 sda released after reset", sda_oe, 0);

        // R1: wrong strap and wrong type nibble
        i2c_start(); send_byte(dev(3'b010, 1'b0), a); chk("R1 wrong strap nack", a, 0); i2c_stop();
        i2c_start(); send_byte({4'b0100, STRAP, 1'b0}, a); chk("R1 wrong type nack", a, 0); i2c_stop();

        cur_read(1, "R12 reset content");

        // byte write, busy window, busy nack
        wbuf[0] = 8'h5A;
        mem_write(8'h10, 1, "byte write");
        chk("R5 busy after stop", busy, 1);
        i2c_start(); send_byte(dev(STRAP, 1'b0), a); chk("R6 nack while busy", a, 0); i2c_stop();
        wait_idle();
        chk("R5 busy length", busy_last, WCYC);
        cur_read(1, "R8 counter after write");
        rand_read(8'h10, 1, "R9 random read");

        // page wrap: six bytes at 0x22
        for (int k = 0; k < 6; k++) wbuf[k] = 8'hA0 + 8'(k);
        mem_write(8'h22, 6, "R3 wrap");
        wait_idle();
        rand_read(8'h20, 5, "R3 R4 page readback");

        // partial page
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        mem_write(8'h41, 2, "R4 partial");
        wait_idle();
        rand_read(8'h40, 4, "R4 masked commit");

        // word address only
        i2c_start(); send_byte(dev(STRAP, 1'b0), a); send_byte(8'h23, a); i2c_stop();
        cnt_m = 8'h23;
        tick(10);
        chk("R7 no write cycle", busy, 0);
        cur_read(1, "R7 counter loaded");

        // sequential roll-over
        wbuf[0] = 8'hC1; wbuf[1] = 8'hC2;
        mem_write(8'hFE, 2, "R10 top"); wait_idle();
        wbuf[0] = 8'hD1; wbuf[1] = 8'hD2;
        mem_write(8'h00, 2, "R10 bottom"); wait_idle();
        rand_read(8'hFD, 5, "R10 rollover");
        cur_read(1, "R10 counter after rollover");

        // write lock
        lock = 1'b1;
        wbuf[0] = 8'h77; wbuf[1] = 8'h78;
        mem_write(8'h30, 2, "R11 locked");
        tick(10);
        chk("R11 no busy when locked", busy, 0);
        lock = 1'b0;
        rand_read(8'h30, 2, "R11 unchanged");

        // seeded random page writes
        for (int it = 0; it < 20; it++) begin
            logic [7:0] wa;
            int len;
            wa  = 8'($urandom % 256);
            len = 1 + int'($urandom % 6);
            for (int k = 0; k < len; k++) wbuf[k] = 8'($urandom);
            mem_write(wa, len, "R3 random write");
            wait_idle();
            if (it % 3 == 0) cur_read(2, "R8 random current");
            rand_read({wa[7:2], 2'b00}, 4, "R4 random readback");
        end

        finish_run();
    end
endmodule